// File: doc/BRIEF.md
# Eight-bit ALU with carry and zero flags

This block is the execute stage datapath of a small 8-bit register-file processor. Each cycle it receives a 6-bit operation code, the destination register value, an 8-bit immediate taken from the instruction word, and the value of a second register. It returns the result to be written back, a write strobe for the destination register, and the next values of the carry and zero flags. The flag pair is held in registers inside the block. The stored carry also serves as the carry-in for the chained add and subtract operations.

The operations are register load and move, three bitwise logic operations, a flag-only bit test, a flag-only compare, and addition and subtraction, each with a variant that chains the carry. The lowest opcode bit selects the second operand: the register value when it is 1, the immediate when it is 0. Flags and the write strobe take effect only while the execute enable is high. Shifts, memory, I/O and branching are handled outside this block.

Top module: `alu8_core`

## Requirements
- R1: Opcode bit 0 selects the second operand: 1 takes `sy_val`, 0 takes `imm_val`.
- R2: Opcodes 000000 and 000001 put the selected operand on `result` with `wr_en` high, and leave both flags unchanged.
- R3: Opcodes 00101x (AND), 00110x (OR) and 00111x (XOR) write the bitwise result of `sx_val` and the operand. They clear carry and set zero exactly when the result is 0.
- R4: Opcodes 01001x (bit test) present `sx_val` AND operand on `result`, keep `wr_en` low, set carry to the odd parity of that value, and set zero when it is 0.
- R5: Opcodes 01010x (compare) present `sx_val` minus operand on `result` and keep `wr_en` low. Carry is set when the operand exceeds `sx_val` and zero when the two are equal. The stored carry plays no part.
- R6: Opcodes 01100x (add) write `sx_val` plus the operand, and 01101x (add with carry) also add the stored carry. Carry takes the carry out of bit 7 and zero is set on an 8-bit result of 0.
- R7: Opcodes 01110x (subtract) write `sx_val` minus the operand, and 01111x (subtract with borrow) also subtract the stored carry. Carry is set on a borrow and zero on an 8-bit result of 0.
- R8: Any other opcode gives `result` 0 and `wr_en` low, and leaves both flags unchanged.
- R9: The flags load `carry_nxt` and `zero_nxt` on a rising clock edge only while `exec_en` is high. `wr_en` is low whenever `exec_en` is low.
- R10: An active-low reset clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute enable for this cycle |
| opcode | input | 6 | Operation code |
| sx_val | input | 8 | Destination register value (first operand) |
| imm_val | input | 8 | Immediate operand |
| sy_val | input | 8 | Second register value |
| result | output | 8 | Computed value |
| wr_en | output | 1 | Destination register write strobe |
| carry_nxt | output | 1 | Carry flag value to be stored |
| zero_nxt | output | 1 | Zero flag value to be stored |
| carry_flag | output | 1 | Stored carry flag |
| zero_flag | output | 1 | Stored zero flag |

## Verification
The only internal state is the flag pair. A wrong stored carry shows up in the same cycle as a wrong `result` and `carry_nxt` on the next add-with-carry or subtract-with-borrow. A wrong stored zero shows up on `zero_nxt` during a move or an unassigned opcode, because those pass the stored flags through. A flag that loads while `exec_en` is low, or fails to load while it is high, therefore becomes visible one edge later on `carry_flag` and `zero_flag`. The vectors set up each carry-in value on purpose before the operation that depends on it.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    K_NONE, K_MOVE, K_AND, K_OR, K_XOR, K_TEST, K_CMP, K_ADD, K_SUB
  } alu_kind_e;

  // Operation family from the opcode; bit 0 only picks the operand source.
  function automatic alu_kind_e decode_kind(input logic [OPC_W-1:0] op);
    case (op[OPC_W-1:1])
      5'b00000:          return K_MOVE;
      5'b00101:          return K_AND;
      5'b00110:          return K_OR;
      5'b00111:          return K_XOR;
      5'b01001:          return K_TEST;
      5'b01010:          return K_CMP;
      5'b01100, 5'b01101: return K_ADD;
      5'b01110, 5'b01111: return K_SUB;
      default:           return K_NONE;
    endcase
  endfunction

  // Carry-chained variants of add and subtract.
  function automatic logic decode_chain(input logic [OPC_W-1:0] op);
    return (op[OPC_W-1:1] == 5'b01101) || (op[OPC_W-1:1] == 5'b01111);
  endfunction
endpackage

// File: rtl/alu8_logic_unit.sv
`timescale 1ns/1ps
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_kind_e     kind,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] val,
  output logic          parity
);
  always_comb begin
    case (kind)
      K_OR:    val = a | b;
      K_XOR:   val = a ^ b;
      default: val = a & b;   // AND and bit test
    endcase
  end

  // Odd parity built as an explicit chain.
  logic [DW:0] par_chain;
  assign par_chain[0] = 1'b0;
  for (genvar i = 0; i < DW; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ val[i];
  end
  assign parity = par_chain[DW];
endmodule

// File: rtl/alu8_arith_unit.sv
`timescale 1ns/1ps
module alu8_arith_unit #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          subtract,
  input  logic          chain,
  input  logic          cin,
  output logic [DW-1:0] val,
  output logic          cflag
);
  localparam int SW = DW + 1;

  // One adder serves both directions: a - b - c == a + ~b + (1 - c).
  function automatic logic [SW-1:0] add_core(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y,
                                             input logic          ci);
    return {1'b0, x} + {1'b0, y} + {{(SW-1){1'b0}}, ci};
  endfunction

  logic          c_used;
  logic [DW-1:0] b_eff;
  logic          ci_eff;
  logic [SW-1:0] sum;

  assign c_used = chain & cin;
  assign b_eff  = subtract ? ~b : b;
  assign ci_eff = subtract ? ~c_used : c_used;
  assign sum    = add_core(a, b_eff, ci_eff);
  assign val    = sum[DW-1:0];
  // Carry out for add, borrow (inverted carry out) for subtract.
  assign cflag  = subtract ? ~sum[DW] : sum[DW];
endmodule

// File: rtl/alu8_flag_reg.sv
`timescale 1ns/1ps
module alu8_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic c_d,
  input  logic z_d,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (load) begin
      c_q <= c_d;
      z_q <= z_d;
    end
  end

  assert_flag_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (c_q == $past(c_d)) && (z_q == $past(z_d)));
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(c_q) && $stable(z_q));
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [5:0]    opcode,
  input  logic [DW-1:0] sx_val,
  input  logic [DW-1:0] imm_val,
  input  logic [DW-1:0] sy_val,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic          carry_nxt,
  output logic          zero_nxt,
  output logic          carry_flag,
  output logic          zero_flag
);
  alu_kind_e     kind;
  logic          chain;
  logic [DW-1:0] operand;
  logic [DW-1:0] logic_val;
  logic          logic_par;
  logic [DW-1:0] arith_val;
  logic          arith_c;
  logic          is_sub;
  logic          writes;
  logic          updates;
  logic          flag_load;

  assign kind    = decode_kind(opcode);
  assign chain   = decode_chain(opcode);
  assign operand = opcode[0] ? sy_val : imm_val;
  assign is_sub  = (kind == K_SUB) || (kind == K_CMP);

  alu8_logic_unit #(.DW(DW)) u_logic (
    .kind(kind), .a(sx_val), .b(operand), .val(logic_val), .parity(logic_par)
  );

  alu8_arith_unit #(.DW(DW)) u_arith (
    .a(sx_val), .b(operand), .subtract(is_sub), .chain(chain),
    .cin(carry_flag), .val(arith_val), .cflag(arith_c)
  );

  always_comb begin
    result    = '0;
    carry_nxt = carry_flag;
    zero_nxt  = zero_flag;
    writes    = 1'b0;
    updates   = 1'b0;
    case (kind)
      K_MOVE: begin
        result = operand;
        writes = 1'b1;
      end
      K_AND, K_OR, K_XOR: begin
        result    = logic_val;
        carry_nxt = 1'b0;
        zero_nxt  = (logic_val == '0);
        writes    = 1'b1;
        updates   = 1'b1;
      end
      K_TEST: begin
        result    = logic_val;
        carry_nxt = logic_par;
        zero_nxt  = (logic_val == '0);
        updates   = 1'b1;
      end
      K_CMP: begin
        result    = arith_val;
        carry_nxt = arith_c;
        zero_nxt  = (arith_val == '0);
        updates   = 1'b1;
      end
      K_ADD, K_SUB: begin
        result    = arith_val;
        carry_nxt = arith_c;
        zero_nxt  = (arith_val == '0);
        writes    = 1'b1;
        updates   = 1'b1;
      end
      default: ;
    endcase
  end

  assign wr_en     = exec_en & writes;
  assign flag_load = exec_en & updates;

  alu8_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .load(flag_load),
    .c_d(carry_nxt), .z_d(zero_nxt), .c_q(carry_flag), .z_q(zero_flag)
  );

  // Without a carry out the sum never wraps below the first operand.
  assert_add_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_ADD && !arith_c) |-> (arith_val >= sx_val));
  // Without a borrow the difference never exceeds the first operand.
  assert_sub_no_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sub && !arith_c) |-> (arith_val <= sx_val));
  // AND result can only hold bits already set in the first operand.
  assert_and_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_AND) |-> ((result & ~sx_val) == '0));
  // Moves and unassigned codes leave the stored flags alone.
  assert_move_keeps_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (kind == K_MOVE || kind == K_NONE))
      |=> $stable(carry_flag) && $stable(zero_flag));
  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !wr_en);
endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [5:0] opcode = '0;
  logic [7:0] sx_val = '0, imm_val = '0, sy_val = '0;
  logic [7:0] result;
  logic       wr_en, carry_nxt, zero_nxt, carry_flag, zero_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .sx_val(sx_val), .imm_val(imm_val), .sy_val(sy_val), .result(result),
    .wr_en(wr_en), .carry_nxt(carry_nxt), .zero_nxt(zero_nxt),
    .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  // {opcode, sx, imm, sy, carry-in, exp result, exp wr, exp C, exp Z}
  localparam logic [41:0] VEC [0:25] = '{
    {6'h00, 8'h12, 8'h5A, 8'hC3, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b1}, // R2 R1 load imm
    {6'h01, 8'h12, 8'h5A, 8'hC3, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b0}, // R2 R1 move reg
    {6'h0A, 8'hF0, 8'h3C, 8'hFF, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0}, // R3 and imm
    {6'h0B, 8'hF0, 8'hFF, 8'h0F, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R3 and reg zero
    {6'h0C, 8'hA0, 8'h05, 8'h00, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b0}, // R3 or imm
    {6'h0D, 8'h00, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R3 or reg zero
    {6'h0E, 8'hFF, 8'h0F, 8'h00, 1'b0, 8'hF0, 1'b1, 1'b0, 1'b0}, // R3 xor imm
    {6'h0F, 8'h55, 8'h00, 8'h55, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R3 xor reg zero
    {6'h12, 8'hF3, 8'h31, 8'h00, 1'b0, 8'h31, 1'b0, 1'b1, 1'b0}, // R4 odd parity
    {6'h13, 8'h0F, 8'h00, 8'h33, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0}, // R4 even parity
    {6'h12, 8'hF0, 8'h0F, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1}, // R4 zero
    {6'h14, 8'h40, 8'h40, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R5 equal
    {6'h15, 8'h10, 8'h00, 8'h20, 1'b0, 8'hF0, 1'b0, 1'b1, 1'b0}, // R5 borrow
    {6'h14, 8'h20, 8'h10, 8'h00, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0}, // R5 carry ignored
    {6'h18, 8'h7F, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0}, // R6 add, cin unused
    {6'h19, 8'h80, 8'h00, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R6 add wrap
    {6'h1A, 8'hFE, 8'h01, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1}, // R6 addcy wrap
    {6'h1B, 8'h10, 8'h00, 8'h20, 1'b1, 8'h31, 1'b1, 1'b0, 1'b0}, // R6 addcy cin=1
    {6'h1A, 8'h10, 8'h20, 8'h00, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0}, // R6 addcy cin=0
    {6'h1C, 8'h05, 8'h05, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R7 sub zero
    {6'h1D, 8'h00, 8'h00, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0}, // R7 sub borrow
    {6'h1E, 8'h05, 8'h04, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R7 subcy cin=1
    {6'h1F, 8'h00, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0}, // R7 subcy borrow
    {6'h1E, 8'h30, 8'h10, 8'h00, 1'b0, 8'h20, 1'b1, 1'b0, 1'b0}, // R7 subcy cin=0
    {6'h02, 8'h11, 8'h22, 8'h33, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1}, // R8 unassigned
    {6'h20, 8'h11, 8'h22, 8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}  // R8 unassigned
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [5:0] op, input logic [7:0] x,
                       input logic [7:0] k, input logic [7:0] y);
    @(negedge clk);
    exec_en = en; opcode = op; sx_val = x; imm_val = k; sy_val = y;
  endtask

  // Add that leaves C and Z both equal to c.
  task automatic set_flags(input logic c);
    drive(1'b1, 6'h18, c ? 8'hFF : 8'h00, 8'h01, 8'h00);
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset flags", {carry_flag, zero_flag}, 2'b00);
    chk("R9 idle strobe", wr_en, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 26; i++) begin
      logic [41:0] v;
      v = VEC[i];
      set_flags(v[11]);
      drive(1'b1, v[41:36], v[35:28], v[27:20], v[19:12]);
      #1;
      chk($sformatf("R1-vector %0d comb", i),
          {result, wr_en, carry_nxt, zero_nxt}, v[10:0]);
      @(posedge clk); #1;
      chk($sformatf("R9 vector %0d flags", i), {carry_flag, zero_flag}, v[1:0]);
    end

    // R9: flags and strobe frozen while exec_en is low
    set_flags(1'b1);
    drive(1'b0, 6'h1C, 8'h00, 8'h01, 8'h00);
    #1;
    chk("R9 no strobe when idle", wr_en, 1'b0);
    @(posedge clk); #1;
    chk("R9 flags held when idle", {carry_flag, zero_flag}, 2'b11);
    drive(1'b1, 6'h1C, 8'h00, 8'h01, 8'h00);
    @(posedge clk); #1;
    chk("R7 borrow loads after enable", {carry_flag, zero_flag}, 2'b10);

    // R10: reset in mid-run clears flags
    set_flags(1'b1);
    drive(1'b0, 6'h00, 8'h00, 8'h00, 8'h00);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", {carry_flag, zero_flag}, 2'b00);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 flags after release", {carry_flag, zero_flag}, 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule